// File: doc/BRIEF.md
# Dual-Rate Activity Duration Timer

This block measures how long a monitored condition stays true, for example a sense input sitting above ground while a battery charges. A single tick input marks one fast-rate count period. While the condition input is high, every tick advances a 16-bit count. When that count first wraps from all-ones to zero, a sticky slow-mode flag is raised. From then on an internal prescaler lets only one tick in 256 through, which stretches the usable range by that factor. A second wrap drops the flag again.

Software reads the count as two bytes, plus a mode byte that carries the flag, over a simple byte-addressed register port. Reading the low byte captures the high byte in a shadow, so a low-then-high read pair always returns one coherent 16-bit value. A write to a dedicated clear address zeroes the count, the flag and the prescaler.

Top module: `act_span_timer`

## Requirements
- R1: After a synchronous reset, the low byte (address 0x65), the high byte (address 0x66) and the mode byte (address 0x64) all read as zero.
- R2: While the flag is clear, each cycle that has both `act_i` and `tick_i` high adds one to the count. The count's low byte reads at 0x65 and its high byte at 0x66.
- R3: A cycle with `act_i` low or `tick_i` low leaves the count unchanged.
- R4: When the count wraps from 0xFFFF to 0x0000 with the flag clear, the flag is set. The flag reads as bit 5 of the mode byte (value 0x20), and the other bits of that byte read 0.
- R5: While the flag is set, the count advances once per 256 qualifying ticks, on the 256th of them.
- R6: A wrap past all-ones while the flag is set clears the flag.
- R7: A write to address 0x67 (any data) zeroes the count, the flag, the prescaler and the shadow. It wins over a qualifying tick in the same cycle.
- R8: A read of 0x65 returns the live low byte and copies the live high byte into a shadow. A read of 0x66 returns the shadow.
- R9: Read data is registered: it appears the cycle after `rd_i` and holds while `rd_i` is low. Unmapped addresses read 0. Writes to any address other than 0x67 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Monitored condition is active |
| tick_i | input | 1 | One fast-rate count period has elapsed |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (ignored by all mapped registers) |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The hardest state to reach from the ports is the second wrap. It lies 256 times further out than the first wrap, which puts it around 16 million ticks away at full width. The bench therefore adds a second instance whose count width is reduced to 8 bits. The prescaler keeps its 256:1 ratio, so the flag-clearing wrap of that instance arrives after about 66 thousand ticks. The full-width instance still covers the first wrap, the slowdown and the coherent byte read across a carry.

// File: rtl/span_pkg.sv
package span_pkg;
  localparam logic [7:0] ADDR_MODE = 8'h64;
  localparam logic [7:0] ADDR_LO   = 8'h65;
  localparam logic [7:0] ADDR_HI   = 8'h66;
  localparam logic [7:0] ADDR_CLR  = 8'h67;
  localparam int         SLOW_BIT  = 5;
endpackage

// File: rtl/span_prescale.sv
module span_prescale #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic slow_i,
  input  logic act_i,
  input  logic tick_i,
  output logic step_o
);
  logic [PRE_W-1:0] pre_q;
  logic             qual;

  assign qual   = act_i & tick_i;
  assign step_o = qual & (~slow_i | (pre_q == '1));

  always_ff @(posedge clk) begin
    if (rst || clr_i)        pre_q <= '0;
    else if (qual && slow_i) pre_q <= pre_q + 1'b1;
  end

  // R5
  pre_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !slow_i |-> pre_q == '0);
endmodule

// File: rtl/span_count.sv
module span_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             slow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             slow_q;
  logic             wrap;

  assign wrap = step_i && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) slow_q <= ~slow_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign slow_o = slow_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !step_i) |=> $stable(cnt_q));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && step_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R7
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0 && !slow_q));
  // R6
  flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(step_i && cnt_q == '1)) |=> $stable(slow_q));
endmodule

// File: rtl/span_regs.sv
module span_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             slow_i,
  output logic             clr_o,
  output logic [7:0]       rdata_o
);
  import span_pkg::*;

  logic [15:0] cnt_ext;
  logic [7:0]  shadow_q;
  logic [7:0]  rdata_q;
  logic [7:0]  mode_byte;

  assign cnt_ext   = 16'(cnt_i);
  assign clr_o     = wr_i && (addr_i == ADDR_CLR);
  assign mode_byte = 8'(slow_i) << SLOW_BIT;

  always_ff @(posedge clk) begin
    if (rst || clr_o)                  shadow_q <= '0;
    else if (rd_i && addr_i == ADDR_LO) shadow_q <= cnt_ext[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_i) begin
      case (addr_i)
        ADDR_MODE: rdata_q <= mode_byte;
        ADDR_LO:   rdata_q <= cnt_ext[7:0];
        ADDR_HI:   rdata_q <= shadow_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/act_span_timer.sv
module act_span_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       act_i,
  input  logic       tick_i,
  input  logic [7:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o
);
  logic             clr;
  logic             slow;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       wdata_unused;

  assign wdata_unused = wdata_i;

  span_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(clr), .slow_i(slow),
    .act_i(act_i), .tick_i(tick_i), .step_o(step)
  );

  span_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(clr), .step_i(step),
    .cnt_o(cnt), .slow_o(slow)
  );

  span_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .cnt_i(cnt), .slow_i(slow), .clr_o(clr), .rdata_o(rdata_o)
  );
endmodule

// File: tb/sim_act_span_timer.sv
module sim_act_span_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       a_act = 0, a_tick = 0, a_wr = 0, a_rd = 0;
  logic [7:0] a_addr = 0, a_wdata = 0, a_rdata;
  logic       b_act = 0, b_tick = 0, b_wr = 0, b_rd = 0;
  logic [7:0] b_addr = 0, b_wdata = 0, b_rdata;

  int checks = 0;
  int fails  = 0;

  act_span_timer u0 (
    .clk(clk), .rst(rst), .act_i(a_act), .tick_i(a_tick), .addr_i(a_addr),
    .wr_i(a_wr), .wdata_i(a_wdata), .rd_i(a_rd), .rdata_o(a_rdata)
  );

  act_span_timer #(.CNT_W(8)) u1 (
    .clk(clk), .rst(rst), .act_i(b_act), .tick_i(b_tick), .addr_i(b_addr),
    .wr_i(b_wr), .wdata_i(b_wdata), .rd_i(b_rd), .rdata_o(b_rdata)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic rd0(input logic [7:0] addr, output logic [7:0] d);
    @(negedge clk); a_addr = addr; a_rd = 1;
    @(posedge clk); #1 d = a_rdata;
    @(negedge clk); a_rd = 0;
  endtask

  task automatic rd1(input logic [7:0] addr, output logic [7:0] d);
    @(negedge clk); b_addr = addr; b_rd = 1;
    @(posedge clk); #1 d = b_rdata;
    @(negedge clk); b_rd = 0;
  endtask

  task automatic wr0(input logic [7:0] addr, input logic [7:0] d);
    @(negedge clk); a_addr = addr; a_wdata = d; a_wr = 1;
    @(negedge clk); a_wr = 0;
  endtask

  task automatic tk0(input int n, input logic act);
    @(negedge clk); a_act = act; a_tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); a_tick = 0; a_act = 0;
  endtask

  task automatic tk1(input int n);
    @(negedge clk); b_act = 1; b_tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); b_tick = 0; b_act = 0;
  endtask

  task automatic cnt0(output int v);
    logic [7:0] lo, hi;
    rd0(8'h65, lo);
    rd0(8'h66, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd0(8'h64, d); check("R1 mode", d, 0);
    rd0(8'h65, d); check("R1 low", d, 0);
    rd0(8'h66, d); check("R1 high", d, 0);
  endtask

  task automatic t_fast;
    int v;
    tk0(10, 1'b1); cnt0(v); check("R2 ten ticks", v, 10);
    tk0(7, 1'b0);  cnt0(v); check("R3 inactive ticks", v, 10);
    @(negedge clk); a_act = 1; a_tick = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); a_act = 0;
    cnt0(v); check("R3 active without tick", v, 10);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    wr0(8'h65, 8'h55);
    wr0(8'h64, 8'hFF);
    rd0(8'h65, d); check("R9 low after stray write", d, 10);
    rd0(8'h64, d); check("R9 mode after stray write", d, 0);
    rd0(8'h70, d); check("R9 unmapped read", d, 0);
    @(negedge clk); @(negedge clk);
    check("R9 data held", a_rdata, 0);
  endtask

  task automatic t_shadow;
    logic [7:0] d;
    wr0(8'h67, 8'h00);
    tk0(255, 1'b1);
    rd0(8'h65, d); check("R8 low before carry", d, 8'hFF);
    tk0(1, 1'b1);
    rd0(8'h66, d); check("R8 shadow keeps old high", d, 8'h00);
    rd0(8'h65, d); check("R8 low after carry", d, 8'h00);
    rd0(8'h66, d); check("R8 new high latched", d, 8'h01);
  endtask

  task automatic t_wrap;
    int v;
    logic [7:0] d;
    wr0(8'h67, 8'h00);
    tk0(65535, 1'b1);
    cnt0(v); check("R2 count at all-ones", v, 16'hFFFF);
    rd0(8'h64, d); check("R4 flag before wrap", d, 0);
    tk0(1, 1'b1);
    cnt0(v); check("R4 count after wrap", v, 0);
    rd0(8'h64, d); check("R4 flag set", d, 8'h20);
  endtask

  task automatic t_slow;
    int v;
    tk0(255, 1'b1); cnt0(v); check("R5 255 slow ticks", v, 0);
    tk0(1, 1'b1);   cnt0(v); check("R5 256th slow tick", v, 1);
    tk0(512, 1'b1); cnt0(v); check("R5 two more periods", v, 3);
  endtask

  task automatic t_clear_prio;
    int v;
    logic [7:0] d;
    @(negedge clk); a_act = 1; a_tick = 1; a_addr = 8'h67; a_wr = 1;
    @(negedge clk); a_act = 0; a_tick = 0; a_wr = 0;
    cnt0(v); check("R7 clear beats tick", v, 0);
    rd0(8'h64, d); check("R7 flag cleared", d, 0);
    tk0(1, 1'b1); cnt0(v); check("R7 fast rate after clear", v, 1);
  endtask

  task automatic t_second_wrap;
    logic [7:0] d;
    tk1(256);
    rd1(8'h64, d); check("R4 narrow first wrap flag", d, 8'h20);
    tk1(65535);
    rd1(8'h65, d); check("R5 narrow slow count", d, 8'hFF);
    rd1(8'h64, d); check("R6 flag before second wrap", d, 8'h20);
    tk1(1);
    rd1(8'h65, d); check("R6 count after second wrap", d, 0);
    rd1(8'h64, d); check("R6 flag cleared", d, 0);
    rd1(8'h66, d); check("R6 narrow high byte", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_fast();
    t_ignore();
    t_shadow();
    t_wrap();
    t_slow();
    t_clear_prio();
    t_second_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule